// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Port

This block lets a controller program the divide ratios of a frequency synthesizer over three slow pins: a serial data line, a serial clock and a load strobe. The pins are asynchronous to the block. They are resampled on a fast system clock, and their rising edges are found there. Each rising edge of the serial clock appends one bit to a 19-bit shift register. A rising edge of the load strobe then commits that register to one of two destination registers.

The last bit shifted in (bit 0) is the control bit, and it picks the word type. A reference word carries a 14-bit reference divide value and a prescaler-select bit. A program word carries a 7-bit swallow count and an 11-bit main counter value. A reference divide value below 3 is forbidden, so such a load is discarded. Each successful write raises a one-cycle update strobe for that register.

The configuration words do not form a stream with back-pressure. The serial pins have no ready path, and the update strobes cannot be stalled. A consumer that needs a value must capture it in the cycle its strobe is high. The register output stays valid after that cycle.

Top module: `serial_synth_cfg`

## Requirements
- R1: While reset is asserted, all latched outputs and both strobes are zero.
- R2: Each rising edge of `ser_clk` shifts `ser_data` into bit 0 of the word, so bits arrive most significant first. Only the 19 most recent bits are kept, and older bits fall out of the top.
- R3: On a load where bit 0 = 1 and bits 14..1 are at least 3, `ref_div` takes bits 14..1 and `pre_sel` takes bit 15. Bits 18..16 have no effect.
- R4: On a load where bit 0 = 0, `swallow` takes bits 7..1 and `main_div` takes bits 18..8.
- R5: A load with bit 0 = 1 and bits 14..1 below 3 changes no output and raises no strobe. A value of exactly 3 is accepted.
- R6: `ref_upd` and `prog_upd` are each high for exactly one cycle per accepted write of their own register. They are never high together.
- R7: The new value and its strobe appear after the third rising system-clock edge that follows the rise of `ser_load`.
- R8: A write to one destination register leaves the other register unchanged.
- R9: Holding `ser_clk` or `ser_load` high produces only one shift or one load. Repetition needs a falling edge and then a new rising edge.
- R10: Falling edges of `ser_clk`, and changes of `ser_data` while `ser_clk` is steady, do not alter the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_data | input | 1 | Serial data line (asynchronous) |
| ser_load | input | 1 | Load strobe, commits on its rising edge (asynchronous) |
| ref_div | output | 14 | Latched reference divide value |
| pre_sel | output | 1 | Latched prescaler-select bit |
| swallow | output | 7 | Latched swallow count |
| main_div | output | 11 | Latched main counter value |
| ref_upd | output | 1 | One-cycle pulse when the reference register is written |
| prog_upd | output | 1 | One-cycle pulse when the program register is written |

## Verification
The assertions rely on a few conditions at the inputs. Each serial pin must stay at a level for at least a few system-clock cycles. `ser_data` must be settled well before a `ser_clk` rise. `ser_load` must be low while reset is asserted and must not rise at the same time as `ser_clk`. The latency property depends on these conditions, because it looks back at the raw load pin four cycles. The stimulus holds each level for three or more cycles and sets data three cycles ahead of every clock rise. It keeps the load strobe low throughout reset. It raises that strobe only after the last serial clock has fallen. These margins stand in, at this clock ratio, for the sub-microsecond setup and hold intervals of the pins.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  parameter int REF_W   = 14;
  parameter int SWL_W   = 7;
  parameter int MAIN_W  = 11;
  parameter int REF_MIN = 3;
  localparam int WORD_W = 1 + SWL_W + MAIN_W;
  localparam int REF_USED = 1 + REF_W + 1;

  typedef struct packed {
    logic             pre;
    logic [REF_W-1:0] div;
  } ref_cfg_t;

  typedef struct packed {
    logic [MAIN_W-1:0] main;
    logic [SWL_W-1:0]  swl;
  } prog_cfg_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int N      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= pin;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign lvl = stg[STAGES-1];
endmodule

// File: rtl/rise_det.sv
module rise_det #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~prev;
  end
endmodule

// File: rtl/shift_in.sv
module shift_in #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word <= '0;
    else if (step) word <= {word[W-2:0], bit_in};
  end
endmodule

// File: rtl/word_router.sv
module word_router
  import synth_cfg_pkg::*;
#(
  parameter int MIN_DIV = REF_MIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [WORD_W-1:0] word,
  output ref_cfg_t          ref_q,
  output prog_cfg_t         prog_q,
  output logic              ref_upd,
  output logic              prog_upd
);
  ref_cfg_t  ref_nxt;
  prog_cfg_t prog_nxt;
  logic      is_ref;
  logic      ref_ok;

  assign is_ref        = word[0];
  assign ref_nxt.div   = word[REF_W:1];
  assign ref_nxt.pre   = word[REF_W+1];
  assign prog_nxt.swl  = word[SWL_W:1];
  assign prog_nxt.main = word[WORD_W-1:SWL_W+1];
  assign ref_ok        = ref_nxt.div >= REF_W'(MIN_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q    <= '0;
      prog_q   <= '0;
      ref_upd  <= 1'b0;
      prog_upd <= 1'b0;
    end else begin
      ref_upd  <= 1'b0;
      prog_upd <= 1'b0;
      if (commit) begin
        if (is_ref) begin
          if (ref_ok) begin
            ref_q   <= ref_nxt;
            ref_upd <= 1'b1;
          end
        end else begin
          prog_q   <= prog_nxt;
          prog_upd <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serial_synth_cfg.sv
module serial_synth_cfg
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_DIV     = REF_MIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_load,
  output logic [REF_W-1:0]  ref_div,
  output logic              pre_sel,
  output logic [SWL_W-1:0]  swallow,
  output logic [MAIN_W-1:0] main_div,
  output logic              ref_upd,
  output logic              prog_upd
);
  logic [2:0]        pin_lvl;
  logic [1:0]        pin_rise;
  logic [WORD_W-1:0] word;
  ref_cfg_t          ref_q;
  prog_cfg_t         prog_q;

  // bit 2: load, bit 1: serial clock, bit 0: data
  pin_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin({ser_load, ser_clk, ser_data}),
    .lvl(pin_lvl)
  );

  rise_det #(.N(2)) u_rise (
    .clk(clk), .rst_n(rst_n),
    .lvl(pin_lvl[2:1]),
    .rise(pin_rise)
  );

  shift_in #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .step(pin_rise[0]),
    .bit_in(pin_lvl[0]),
    .word(word)
  );

  word_router #(.MIN_DIV(MIN_DIV)) u_route (
    .clk(clk), .rst_n(rst_n),
    .commit(pin_rise[1]),
    .word(word),
    .ref_q(ref_q),
    .prog_q(prog_q),
    .ref_upd(ref_upd),
    .prog_upd(prog_upd)
  );

  assign ref_div  = ref_q.div;
  assign pre_sel  = ref_q.pre;
  assign swallow  = prog_q.swl;
  assign main_div = prog_q.main;
endmodule

// File: rtl/synth_cfg_chk.sv
module synth_cfg_chk
  import synth_cfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ser_load,
  input logic [REF_W-1:0]  ref_div,
  input logic              pre_sel,
  input logic [SWL_W-1:0]  swallow,
  input logic [MAIN_W-1:0] main_div,
  input logic              ref_upd,
  input logic              prog_upd
);
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_upd && prog_upd));

  // R6
  ref_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_upd |=> !ref_upd);

  // R6
  prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_upd |=> !prog_upd);

  // R5
  ref_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_upd |-> (ref_div >= REF_W'(REF_MIN)));

  // R8
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_upd |-> (ref_div == $past(ref_div) && pre_sel == $past(pre_sel)));

  // R8
  prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_upd |-> (swallow == $past(swallow) && main_div == $past(main_div)));

  // R7
  upd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_upd || prog_upd) |-> ($past(ser_load, 3) && !$past(ser_load, 4)));
endmodule

bind serial_synth_cfg synth_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ser_load(ser_load),
  .ref_div(ref_div), .pre_sel(pre_sel), .swallow(swallow),
  .main_div(main_div), .ref_upd(ref_upd), .prog_upd(prog_upd)
);

// File: tb/sim_serial_synth_cfg.sv
module sim_serial_synth_cfg;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic [13:0] ref_div;
  logic        pre_sel;
  logic [6:0]  swallow;
  logic [10:0] main_div;
  logic        ref_upd, prog_upd;

  int errors = 0, checks = 0;
  int n_rupd = 0, n_pupd = 0;

  always #(CLK_P/2) clk = ~clk;

  serial_synth_cfg u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .ref_div(ref_div), .pre_sel(pre_sel),
    .swallow(swallow), .main_div(main_div), .ref_upd(ref_upd),
    .prog_upd(prog_upd)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model: pin history queues, integer fields
  bit q_ck[$], q_dt[$], q_ld[$];
  logic [18:0] m_word;
  int m_ref, m_pre, m_swl, m_main;
  bit m_rupd, m_pupd;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_ck = '{0, 0, 0, 0}; q_dt = '{0, 0, 0, 0}; q_ld = '{0, 0, 0, 0};
      m_word = '0; m_ref = 0; m_pre = 0; m_swl = 0; m_main = 0;
      m_rupd = 0; m_pupd = 0;
    end else begin
      q_ck.push_front(ser_clk);  void'(q_ck.pop_back());
      q_dt.push_front(ser_data); void'(q_dt.pop_back());
      q_ld.push_front(ser_load); void'(q_ld.pop_back());
      m_rupd = 0; m_pupd = 0;
      if (q_ld[2] && !q_ld[3]) begin
        if (m_word[0]) begin
          if (int'(m_word[14:1]) >= 3) begin
            m_ref = int'(m_word[14:1]); m_pre = int'(m_word[15]); m_rupd = 1;
          end
        end else begin
          m_swl = int'(m_word[7:1]); m_main = int'(m_word[18:8]); m_pupd = 1;
        end
      end
      if (q_ck[2] && !q_ck[3]) m_word = {m_word[17:0], q_dt[2]};
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(ref_div == 14'(m_ref) && pre_sel == 1'(m_pre), "R3 ref model",
          {ref_div, pre_sel}, (m_ref << 1) | m_pre);
      chk(swallow == 7'(m_swl) && main_div == 11'(m_main), "R4 prog model",
          {main_div, swallow}, (m_main << 7) | m_swl);
      chk(ref_upd == m_rupd && prog_upd == m_pupd, "R6 strobe model",
          {ref_upd, prog_upd}, {m_rupd, m_pupd});
      if (ref_upd)  n_rupd++;
      if (prog_upd) n_pupd++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // data settles first, flips while the clock is high (R10)
  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i];
      cyc(3);
      ser_clk = 1'b1;
      cyc(2);
      ser_data = ~v[i];
      cyc(2);
      ser_clk = 1'b0;
      cyc(3);
    end
  endtask

  task automatic pulse_load();
    ser_load = 1'b1; cyc(6); ser_load = 1'b0; cyc(4);
  endtask

  task automatic send_word(input logic [18:0] w);
    send_bits({13'd0, w}, 19);
    pulse_load();
  endtask

  function automatic logic [18:0] ref_word(input int r, input bit p, input logic [2:0] junk);
    return {junk, p, 14'(r), 1'b1};
  endfunction

  function automatic logic [18:0] prog_word(input int a, input int b);
    return {11'(b), 7'(a), 1'b0};
  endfunction

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    logic [18:0] w;
    cyc(3);
    // R1: reset state
    chk(ref_div == 0 && pre_sel == 0, "R1 ref reset", {ref_div, pre_sel}, 0);
    chk(swallow == 0 && main_div == 0, "R1 prog reset", {main_div, swallow}, 0);
    chk(!ref_upd && !prog_upd, "R1 strobes reset", {ref_upd, prog_upd}, 0);
    rst_n = 1'b1;
    cyc(3);

    // R3: reference word, unused top bits set
    send_word(ref_word(5, 1, 3'b101));
    chk(ref_div == 5, "R3 ref_div", ref_div, 5);
    chk(pre_sel == 1, "R3 pre_sel", pre_sel, 1);
    chk(swallow == 0 && main_div == 0, "R8 prog untouched", {main_div, swallow}, 0);
    chk(n_rupd == 1 && n_pupd == 0, "R6 one ref pulse", n_rupd * 10 + n_pupd, 10);

    // R4: program word
    send_word(prog_word(85, 1234));
    chk(swallow == 85, "R4 swallow", swallow, 85);
    chk(main_div == 1234, "R4 main_div", main_div, 1234);
    chk(ref_div == 5 && pre_sel == 1, "R8 ref untouched", ref_div, 5);

    // R5: forbidden reference values
    base = n_rupd;
    send_word(ref_word(2, 0, 3'b000));
    chk(ref_div == 5 && pre_sel == 1, "R5 reject 2", ref_div, 5);
    send_word(ref_word(0, 0, 3'b111));
    chk(ref_div == 5 && pre_sel == 1, "R5 reject 0", ref_div, 5);
    chk(n_rupd == base, "R5 no strobe", n_rupd, base);
    send_word(ref_word(3, 0, 3'b000));
    chk(ref_div == 3 && pre_sel == 0, "R5 accept 3", ref_div, 3);

    // R7 latency and R9 held load
    send_bits({13'd0, ref_word(16383, 0, 3'b010)}, 19);
    base = n_rupd;
    ser_load = 1'b1;
    cyc(2);
    chk(ref_div == 3 && !ref_upd, "R7 not yet after 2 edges", ref_div, 3);
    cyc(1);
    chk(ref_div == 16383 && ref_upd, "R7 value at third edge", ref_div, 16383);
    cyc(20);
    chk(n_rupd == base + 1, "R9 held load single commit", n_rupd, base + 1);
    ser_load = 1'b0;
    cyc(4);

    // R9: serial clock held high for the last bit gives a single shift
    w = prog_word(127, 2047);
    send_bits({13'd0, w[18:1]}, 18);
    ser_data = w[0]; cyc(3);
    ser_clk = 1'b1; cyc(30);
    ser_clk = 1'b0; cyc(3);
    pulse_load();
    chk(swallow == 127 && main_div == 2047, "R9 held clock single shift",
        {main_div, swallow}, {11'd2047, 7'd127});

    // R2: more than 19 bits, the oldest fall out
    send_bits({9'd0, 4'b1011, prog_word(17, 300)}, 23);
    pulse_load();
    chk(swallow == 17 && main_div == 300, "R2 overflow keeps last 19",
        {main_div, swallow}, {11'd300, 7'd17});

    // R10: data wiggles with clock low do not shift
    send_bits({13'd0, prog_word(64, 1024)}, 19);
    for (int k = 0; k < 6; k++) begin
      ser_data = ~ser_data; cyc(4);
    end
    pulse_load();
    chk(swallow == 64 && main_div == 1024, "R10 idle data ignored",
        {main_div, swallow}, {11'd1024, 7'd64});
    chk(ref_div == 16383 && pre_sel == 0, "R8 ref kept", ref_div, 16383);

    cyc(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule